// File: doc/BRIEF.md
# OTG B-Device Host Negotiation Controller

This block lets a dual-role USB port that starts out as the peripheral (the B-device) take the host role from the A-device and later give it back. Software arms an attempt with three configuration bits. The block watches the line for a suspended bus, timing it with an external 1 ms tick. When the suspend is confirmed and the attempt is armed, it drops its D+ pull-up so that the bus sits at SE0, and it enables both D+ and D- pulldowns. It then waits a bounded time for the peer to raise its own pull-up.

If the peer connects in time, the block reports success, raises a status-change interrupt and switches its mode flag to host. Software then commands a port reset, which the block holds for a fixed number of milliseconds before it enters normal host operation. When software suspends the bus and the peer disconnects, the block drops its pulldowns and reconnects as a device. If the peer does not connect in time, the interrupt still fires, the success bit stays clear and the block reconnects as a device. In both cases the block emits a one-cycle pulse so that the request bit can be cleared.

All inputs and outputs are plain control and status pins. The block carries no data stream, so it has no valid/ready handshake.

Top module: `otg_hnp_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `pullup_en` is 1 and `dp_pd_en`, `dm_pd_en`, `host_mode`, `hns`, `hns_chg_irq`, `hnp_req_clr`, `prt_rst_req`, `early_susp` and `usb_susp` are all 0.
- R2: `line_state` encodes SE0 as 2'b00, J (idle) as 2'b01 and K as 2'b10. In the device role, `early_susp` rises after EARLY_MS consecutive `ms_tick` pulses with the line at J. `usb_susp` rises after EARLY_MS+SUSP_GAP_MS such pulses. Any cycle in which the line is not J clears both flags.
- R3: If any of `cfg_hnp_cap`, `dev_hnp_en` or `hnp_req` is 0 when `usb_susp` is set, the block stays a connected device: `pullup_en` stays 1, the pulldowns stay off and no interrupt is raised.
- R4: If all three bits are 1 while `usb_susp` is set, then one clock later `pullup_en` is 0, both pulldown enables are 1 and `host_mode` is still 0. This state holds until the peer connects or the window ends.
- R5: If `peer_conn` is seen before the WIN_MS-th tick of the window, then on the next clock `host_mode` and `hns` are 1 and `hns_chg_irq` and `hnp_req_clr` are each high for exactly one cycle. A connect that arrives in the same cycle as the final window tick counts as success.
- R6: If the WIN_MS-th tick passes with no connect, then on that clock `hns_chg_irq` and `hnp_req_clr` pulse for one cycle, `hns` is 0, `pullup_en` is 1, the pulldowns are off and `host_mode` is 0.
- R7: A one-cycle `prt_rst_cmd` in the host role after success raises `prt_rst_req` on the next clock and holds it for exactly RST_MS ticks. In the device role the command is ignored.
- R8: In the host role, a `peer_conn` drop before `port_suspend` is ignored. After `port_suspend`, a `peer_conn` drop returns the block to device mode on the next clock: pulldowns off, `pullup_en` 1, `host_mode` 0, with `hns` kept at 1.
- R9: The idle timer is held clear outside the device role. On return to device mode, `early_susp` is 0 until EARLY_MS fresh ticks of J have been counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hnp_cap | input | 1 | Port is configured as negotiation-capable |
| dev_hnp_en | input | 1 | Peer has enabled negotiation |
| hnp_req | input | 1 | Software asks for a negotiation attempt |
| line_state | input | 2 | Bus line: 00 SE0, 01 J, 10 K |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| peer_conn | input | 1 | Peer pull-up detected on D+ |
| prt_rst_cmd | input | 1 | Software port-reset command |
| port_suspend | input | 1 | Software command to suspend the bus as host |
| pullup_en | output | 1 | Own D+ pull-up enable |
| dp_pd_en | output | 1 | D+ pulldown enable |
| dm_pd_en | output | 1 | D- pulldown enable |
| host_mode | output | 1 | Current mode: 1 host, 0 device |
| hns | output | 1 | Host negotiation success |
| hns_chg_irq | output | 1 | One-cycle status-change interrupt |
| hnp_req_clr | output | 1 | One-cycle pulse that clears the request bit |
| prt_rst_req | output | 1 | Port reset signalling active |
| early_susp | output | 1 | Early-suspend flag |
| usb_susp | output | 1 | Suspend flag |

## Verification
The bench sweeps all seven incompletely armed bit combinations. A design that ignored one of the three bits would disconnect when it should not. It sweeps the connect time across every tick of the window, including a connect on the same cycle as the final tick. An off-by-one window, or a timeout given priority over the connect, would then report failure where success is due. The idle sweep checks each tick count and a glitch in the middle of an idle run, which would expose a counter that skips the clear or flags suspend too early. The host phase checks the exact length of the reset pulse, a disconnect that must be ignored before suspend, and a fresh idle count after the block returns to device mode. A design that missed any of these would hold reset for the wrong time, drop the host role early or disconnect again at once.

// File: rtl/otg_hnp_pkg.sv
package otg_hnp_pkg;
  typedef enum logic [2:0] {
    ST_DEV,
    ST_DISC,
    ST_HIDLE,
    ST_HRST,
    ST_HOST,
    ST_HSUSP
  } role_st_e;

  localparam logic [1:0] LINE_SE0 = 2'b00;
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
endpackage

// File: rtl/hnp_idle_timer.sv
module hnp_idle_timer #(
  parameter int EARLY_MS    = 3,
  parameter int SUSP_GAP_MS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic line_j,
  input  logic ms_tick,
  output logic early_susp,
  output logic usb_susp
);
  localparam int SUSP_MS = EARLY_MS + SUSP_GAP_MS;
  localparam int CW      = $clog2(SUSP_MS + 1);

  logic [CW-1:0] idle_ms;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || !line_j) idle_ms <= '0;
    else if (ms_tick && idle_ms != CW'(SUSP_MS)) idle_ms <= idle_ms + 1'b1;
  end

  assign early_susp = (idle_ms >= CW'(EARLY_MS));
  assign usb_susp   = (idle_ms == CW'(SUSP_MS));

  // suspend never shows without the early flag
  assert_susp_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    usb_susp |-> early_susp);
  // a non-idle line clears the run
  assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_j |=> !early_susp);
  // outside the device role the timer stays clear
  assert_held_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !early_susp);
endmodule

// File: rtl/hnp_tick_cnt.sv
module hnp_tick_cnt #(
  parameter int MAXV = 3,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign last = tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/hnp_role_fsm.sv
module hnp_role_fsm
  import otg_hnp_pkg::*;
#(
  parameter int WIN_MS = 3,
  parameter int RST_MS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic usb_susp,
  input  logic peer_conn,
  input  logic prt_rst_cmd,
  input  logic port_suspend,
  input  logic ms_tick,
  output logic pullup_en,
  output logic pd_en,
  output logic host_mode,
  output logic hns,
  output logic irq,
  output logic req_clr,
  output logic prt_rst_req,
  output logic idle_en
);
  localparam int MAXV = (WIN_MS > RST_MS) ? WIN_MS : RST_MS;
  localparam int W    = $clog2(MAXV + 1);

  role_st_e state, state_nx;
  logic     cnt_last;
  logic     cnt_clr;
  logic [W-1:0] cnt_limit;

  assign cnt_clr   = (state_nx != state);
  assign cnt_limit = (state == ST_HRST) ? W'(RST_MS) : W'(WIN_MS);

  hnp_tick_cnt #(.MAXV(MAXV)) u_win_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (ms_tick),
    .limit (cnt_limit),
    .last  (cnt_last)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_DEV:   if (usb_susp && armed) state_nx = ST_DISC;
      ST_DISC:  if (peer_conn) state_nx = ST_HIDLE;
                else if (cnt_last) state_nx = ST_DEV;
      ST_HIDLE: if (prt_rst_cmd) state_nx = ST_HRST;
      ST_HRST:  if (cnt_last) state_nx = ST_HOST;
      ST_HOST:  if (port_suspend) state_nx = ST_HSUSP;
      ST_HSUSP: if (!peer_conn) state_nx = ST_DEV;
      default:  state_nx = ST_DEV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_DEV;
      hns     <= 1'b0;
      irq     <= 1'b0;
      req_clr <= 1'b0;
    end else begin
      state   <= state_nx;
      irq     <= 1'b0;
      req_clr <= 1'b0;
      if (state == ST_DEV && state_nx == ST_DISC) hns <= 1'b0;
      if (state == ST_DISC && state_nx != ST_DISC) begin
        irq     <= 1'b1;
        req_clr <= 1'b1;
        hns     <= (state_nx == ST_HIDLE);
      end
    end
  end

  assign pullup_en   = (state == ST_DEV);
  assign pd_en       = (state != ST_DEV);
  assign host_mode   = (state == ST_HIDLE) || (state == ST_HRST) ||
                       (state == ST_HOST)  || (state == ST_HSUSP);
  assign prt_rst_req = (state == ST_HRST);
  assign idle_en     = (state == ST_DEV);

  assert_no_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && !armed) |=> (state == ST_DEV));
  assert_disc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && armed && usb_susp) |=> (!pullup_en && pd_en && !host_mode));
  assert_conn_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DISC && peer_conn) |=> (host_mode && hns && irq && req_clr));
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DISC && !peer_conn && cnt_last) |=> (pullup_en && !hns && irq));
  assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prt_rst_req) |-> $past(prt_rst_cmd));
  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HSUSP && !peer_conn) |=> (pullup_en && !pd_en && !host_mode));
endmodule

// File: rtl/otg_hnp_ctrl.sv
module otg_hnp_ctrl
  import otg_hnp_pkg::*;
#(
  parameter int EARLY_MS    = 3,
  parameter int SUSP_GAP_MS = 1,
  parameter int WIN_MS      = 3,
  parameter int RST_MS      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_hnp_cap,
  input  logic       dev_hnp_en,
  input  logic       hnp_req,
  input  logic [1:0] line_state,
  input  logic       ms_tick,
  input  logic       peer_conn,
  input  logic       prt_rst_cmd,
  input  logic       port_suspend,
  output logic       pullup_en,
  output logic       dp_pd_en,
  output logic       dm_pd_en,
  output logic       host_mode,
  output logic       hns,
  output logic       hns_chg_irq,
  output logic       hnp_req_clr,
  output logic       prt_rst_req,
  output logic       early_susp,
  output logic       usb_susp
);
  logic armed;
  logic idle_en;
  logic pd_en;

  assign armed = cfg_hnp_cap && dev_hnp_en && hnp_req;

  hnp_idle_timer #(.EARLY_MS(EARLY_MS), .SUSP_GAP_MS(SUSP_GAP_MS)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (idle_en),
    .line_j     (line_state == LINE_J),
    .ms_tick    (ms_tick),
    .early_susp (early_susp),
    .usb_susp   (usb_susp)
  );

  hnp_role_fsm #(.WIN_MS(WIN_MS), .RST_MS(RST_MS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .armed        (armed),
    .usb_susp     (usb_susp),
    .peer_conn    (peer_conn),
    .prt_rst_cmd  (prt_rst_cmd),
    .port_suspend (port_suspend),
    .ms_tick      (ms_tick),
    .pullup_en    (pullup_en),
    .pd_en        (pd_en),
    .host_mode    (host_mode),
    .hns          (hns),
    .irq          (hns_chg_irq),
    .req_clr      (hnp_req_clr),
    .prt_rst_req  (prt_rst_req),
    .idle_en      (idle_en)
  );

  assign dp_pd_en = pd_en;
  assign dm_pd_en = pd_en;

  assert_pull_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pullup_en && (dp_pd_en || dm_pd_en)));
endmodule

// File: tb/test_otg_hnp_ctrl.sv
module test_otg_hnp_ctrl;
  localparam int EARLY = 3;
  localparam int GAP   = 1;
  localparam int WIN   = 3;
  localparam int RSTT  = 2;
  localparam logic [1:0] L_SE0 = 2'b00, L_J = 2'b01, L_K = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_hnp_cap = 1'b0, dev_hnp_en = 1'b0, hnp_req = 1'b0;
  logic [1:0] line_state = L_K;
  logic ms_tick = 1'b0, peer_conn = 1'b0, prt_rst_cmd = 1'b0, port_suspend = 1'b0;
  logic pullup_en, dp_pd_en, dm_pd_en, host_mode, hns, hns_chg_irq;
  logic hnp_req_clr, prt_rst_req, early_susp, usb_susp;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;

  always #4 clk = ~clk;

  otg_hnp_ctrl #(.EARLY_MS(EARLY), .SUSP_GAP_MS(GAP), .WIN_MS(WIN), .RST_MS(RSTT)) i_otg_hnp_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_hnp_cap(cfg_hnp_cap), .dev_hnp_en(dev_hnp_en),
    .hnp_req(hnp_req), .line_state(line_state), .ms_tick(ms_tick), .peer_conn(peer_conn),
    .prt_rst_cmd(prt_rst_cmd), .port_suspend(port_suspend), .pullup_en(pullup_en),
    .dp_pd_en(dp_pd_en), .dm_pd_en(dm_pd_en), .host_mode(host_mode), .hns(hns),
    .hns_chg_irq(hns_chg_irq), .hnp_req_clr(hnp_req_clr), .prt_rst_req(prt_rst_req),
    .early_susp(early_susp), .usb_susp(usb_susp)
  );

  always @(posedge clk) if (rst_n && hns_chg_irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic host_phase();
    // R7: reset pulse length
    prt_rst_cmd = 1'b1; step(); prt_rst_cmd = 1'b0;
    check("R7 reset raised", prt_rst_req, 1);
    for (int i = 1; i <= RSTT; i++) begin
      tick();
      check("R7 reset length", prt_rst_req, (i < RSTT) ? 1 : 0);
    end
    check("R7 host after reset", host_mode, 1);
    // R9: idle line in host role does not count
    line_state = L_J;
    repeat (EARLY + 2) tick();
    // R8: disconnect before suspend ignored
    peer_conn = 1'b0; step();
    check("R8 early disconnect ignored", host_mode, 1);
    peer_conn = 1'b1;
    port_suspend = 1'b1; step(); port_suspend = 1'b0;
    check("R8 suspended still host", host_mode, 1);
    check("R8 pulldowns kept", dp_pd_en, 1);
    peer_conn = 1'b0; step();
    check("R8 device mode", host_mode, 0);
    check("R8 pullup on", pullup_en, 1);
    check("R8 pulldown off", dm_pd_en, 0);
    check("R8 hns kept", hns, 1);
    check("R9 idle fresh", early_susp, 0);
    repeat (EARLY - 1) tick();
    check("R9 not yet early", early_susp, 0);
    tick();
    check("R9 early after fresh run", early_susp, 1);
    line_state = L_K; step();
  endtask

  // k ticks before connect; race puts connect on the final window tick
  task automatic attempt(input int k, input bit race);
    int irq0;
    cfg_hnp_cap = 1'b1; dev_hnp_en = 1'b1; hnp_req = 1'b1;
    line_state = L_J;
    repeat (EARLY + GAP) tick();
    check("R2 suspend seen", usb_susp, 1);
    step();
    check("R4 pullup off", pullup_en, 0);
    check("R4 pulldowns on", dp_pd_en & dm_pd_en, 1);
    check("R4 still device", host_mode, 0);
    line_state = L_SE0;
    irq0 = irq_cnt;
    for (int i = 0; i < k; i++) begin
      tick();
      if (i < WIN - 1) check("R4 window holds", pullup_en, 0);
    end
    if (race) begin
      peer_conn = 1'b1; ms_tick = 1'b1; step(); ms_tick = 1'b0;
    end else if (k < WIN) begin
      peer_conn = 1'b1; step();
    end
    if (race || k < WIN) begin
      check("R5 host", host_mode, 1);
      check("R5 hns", hns, 1);
      check("R5 irq", hns_chg_irq, 1);
      check("R5 req clear", hnp_req_clr, 1);
      hnp_req = 1'b0;
      step();
      check("R5 irq one cycle", hns_chg_irq, 0);
      check("R5 req clear one cycle", hnp_req_clr, 0);
      check("R5 single irq", irq_cnt - irq0, 1);
      host_phase();
    end else begin
      check("R6 irq", hns_chg_irq, 1);
      check("R6 req clear", hnp_req_clr, 1);
      check("R6 hns clear", hns, 0);
      check("R6 pullup", pullup_en, 1);
      check("R6 pulldown off", dp_pd_en, 0);
      check("R6 device", host_mode, 0);
      hnp_req = 1'b0;
      step();
      check("R6 irq one cycle", hns_chg_irq, 0);
      line_state = L_K; step();
    end
  endtask

  initial begin
    repeat (3) step();
    check("R1 pullup in reset", pullup_en, 1);
    check("R1 pulldown in reset", dp_pd_en | dm_pd_en, 0);
    rst_n = 1'b1;
    step();
    check("R1 pullup", pullup_en, 1);
    check("R1 host_mode", host_mode, 0);
    check("R1 hns", hns, 0);
    check("R1 irq", hns_chg_irq, 0);
    check("R1 req clear", hnp_req_clr, 0);
    check("R1 port reset", prt_rst_req, 0);
    check("R1 suspend flags", early_susp | usb_susp, 0);

    // R7: reset command ignored in device role
    prt_rst_cmd = 1'b1; step(); prt_rst_cmd = 1'b0; step();
    check("R7 ignored in device", prt_rst_req, 0);
    check("R7 still device", host_mode, 0);

    // R2: idle count sweep
    line_state = L_J;
    for (int n = 1; n <= EARLY + GAP + 1; n++) begin
      tick();
      check("R2 early flag", early_susp, (n >= EARLY) ? 1 : 0);
      check("R2 suspend flag", usb_susp, (n >= EARLY + GAP) ? 1 : 0);
    end
    line_state = L_K; step();
    check("R2 clear on activity", early_susp | usb_susp, 0);
    line_state = L_J;
    repeat (EARLY - 1) tick();
    line_state = L_K; step();
    line_state = L_J;
    repeat (EARLY - 1) tick();
    check("R2 glitch restarts run", early_susp, 0);
    line_state = L_K; step();

    // R3: every combination short of fully armed
    for (int c = 0; c < 7; c++) begin
      int irq0;
      irq0 = irq_cnt;
      cfg_hnp_cap = c[0]; dev_hnp_en = c[1]; hnp_req = c[2];
      line_state = L_J;
      repeat (EARLY + GAP + 1) tick();
      step(); step();
      check("R3 pullup kept", pullup_en, 1);
      check("R3 no pulldown", dp_pd_en, 0);
      check("R3 no irq", irq_cnt - irq0, 0);
      line_state = L_K; step();
    end

    // R5 / R6: connect time sweep across the window
    for (int k = 0; k <= WIN; k++) attempt(k, 1'b0);
    attempt(WIN - 1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule